// File: doc/BRIEF.md
# Transmit Descriptor Status and Control Register

This block is a single 32-bit status and control word kept for one transmit descriptor of a fast Ethernet MAC. The transmit engine reports how a frame send went through single-cycle event pulses. The word keeps them as sticky flags: carrier lost, aborted, late (out-of-window) collision, transmit OK and underrun. It also keeps a saturating count of the collisions seen during the send. A heartbeat supervisor runs a timed window after each completed send. If the transceiver's collision-detect pulse does not arrive inside that window, the supervisor raises a missing-heartbeat flag. The window and the flag are disabled while the link runs at 100 Mbps.

The host reads the whole word at any time. It writes the word only as a full 32-bit access. A write loads the early transmit threshold, the ownership bit and the frame byte count. Loading the byte count is the signal that a new frame is being handed over, so every honoured write also clears all status fields. Data written into status positions is discarded. A software reset clears everything except the ownership bit.

Top module: `txdesc_status_reg`

## Requirements
- R1: While `rst_n` is low at a clock edge, the word resets to 0x0000_2000: the ownership bit (bit 13) is 1 and every other bit is 0.
- R2: A write with `host_be` equal to 4'hF loads bits 21:16 (early transmit threshold), bit 13 (ownership) and bits 12:0 (byte count) from `host_wdata`, visible on `host_rdata` after the next clock edge. A write with any byte enable low changes no bit of the word.
- R3: Bits 31:28, 27:24, 15 and 14 never take a value from `host_wdata`. Reserved bits 23:22 always read 0.
- R4: An honoured write clears bits 31:28, 27:24, 15 and 14. If a status event arrives in the same cycle, the clear wins.
- R5: One-cycle pulses set sticky flags at the next clock edge: `ev_carrier_lost` sets bit 31, `ev_abort` sets bit 30, `ev_late_coll` sets bit 29, `ev_tx_ok` sets bit 15 and `ev_underrun` sets bit 14.
- R6: Each `ev_collision` pulse adds one to bits 27:24. The count stops at 15 and does not wrap.
- R7: After an `ev_tx_done` pulse at 10 Mbps, bit 28 is set at the HB_CYCLES-th clock edge after the pulse's edge, unless `hb_pulse` is high at one of those HB_CYCLES edges.
- R8: While `speed_100` is high, bit 28 reads 0 and no heartbeat window runs.
- R9: A `soft_rst` pulse clears every bit except bit 13, which keeps its value. It takes priority over a write in the same cycle.
- R10: The heartbeat window lasts HB_CYCLES = CLK_KHZ*64/10000 clock cycles, which is 6.4 µs of the clock. That is 320 cycles at the default 50 MHz.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| soft_rst | input | 1 | Software reset pulse; ownership bit kept |
| host_wr | input | 1 | Host write strobe |
| host_be | input | 4 | Host byte enables; all four needed for a write |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Current register word |
| ev_carrier_lost | input | 1 | Carrier dropped during send |
| ev_abort | input | 1 | Send aborted |
| ev_late_coll | input | 1 | Out-of-window collision |
| ev_collision | input | 1 | One collision occurred |
| ev_tx_ok | input | 1 | Frame sent successfully |
| ev_underrun | input | 1 | FIFO underrun during send |
| ev_tx_done | input | 1 | Send finished; starts heartbeat window |
| hb_pulse | input | 1 | Collision-detect heartbeat from transceiver |
| speed_100 | input | 1 | High at 100 Mbps; disables heartbeat check |

## Verification
Writes, software resets, event flags and collision-count steps all appear on `host_rdata` after exactly one clock edge. The bench applies each stimulus before an edge and samples the word a short delay after that edge, then compares it with a model word that the bench's own function advances by one step. The heartbeat flag is due HB_CYCLES edges after the `ev_tx_done` edge. The bench checks that it is still clear one edge earlier and set at that edge. It also checks that a heartbeat arriving on the final window edge still prevents the flag.

// File: rtl/txs_pkg.sv
// Package: bit positions of the descriptor status word and the heartbeat
// window length helper. Assumes a 32-bit register word.
package txs_pkg;
    localparam int WORD_W   = 32;
    localparam int BC_W     = 13;
    localparam int THR_W    = 6;
    localparam int NCC_W    = 4;

    localparam int POS_CRS  = 31;
    localparam int POS_ABT  = 30;
    localparam int POS_OWC  = 29;
    localparam int POS_HBM  = 28;
    localparam int POS_NCC  = 24;
    localparam int POS_THR  = 16;
    localparam int POS_TOK  = 15;
    localparam int POS_TUN  = 14;
    localparam int POS_OWN  = 13;

    // Cycles in 6.4 us for a clock given in kHz.
    function automatic int hb_cycles(input int clk_khz);
        return (clk_khz * 64) / 10000;
    endfunction
endpackage

// File: rtl/txs_host_regs.sv
// Host-writable fields: early transmit threshold, ownership bit and byte
// count. Assumes wr_ok is already qualified by all byte enables.
module txs_host_regs
    import txs_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             soft_rst,
    input  logic             wr_ok,
    input  logic             wr_partial,
    input  logic [THR_W-1:0] wr_thr,
    input  logic             wr_own,
    input  logic [BC_W-1:0]  wr_bc,
    output logic [THR_W-1:0] thr,
    output logic             own,
    output logic [BC_W-1:0]  bc
);
    // Load fields on an honoured write; software reset keeps ownership.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            thr <= '0;
            own <= 1'b1;
            bc  <= '0;
        end else if (soft_rst) begin
            thr <= '0;
            bc  <= '0;
        end else if (wr_ok) begin
            thr <= wr_thr;
            own <= wr_own;
            bc  <= wr_bc;
        end
    end

    // R2: a partial write leaves every host field unchanged.
    a_r2_partial_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_partial && !soft_rst) |=> ($stable(thr) && $stable(own) && $stable(bc)));
    // R9: software reset keeps the ownership bit.
    a_r9_own_kept: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> $stable(own));
endmodule

// File: rtl/txs_status_flags.sv
// Sticky outcome flags and saturating collision counter. Assumes events
// are single-cycle pulses; clr has priority over every event.
module txs_status_flags
    import txs_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             ev_carrier_lost,
    input  logic             ev_abort,
    input  logic             ev_late_coll,
    input  logic             ev_collision,
    input  logic             ev_tx_ok,
    input  logic             ev_underrun,
    output logic             crs,
    output logic             abt,
    output logic             owc,
    output logic             tok,
    output logic             tun,
    output logic [NCC_W-1:0] ncc
);
    localparam logic [NCC_W-1:0] NCC_MAX = '1;

    // Set flags on events, clear all of them on clr.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            crs <= 1'b0;
            abt <= 1'b0;
            owc <= 1'b0;
            tok <= 1'b0;
            tun <= 1'b0;
        end else begin
            crs <= crs | ev_carrier_lost;
            abt <= abt | ev_abort;
            owc <= owc | ev_late_coll;
            tok <= tok | ev_tx_ok;
            tun <= tun | ev_underrun;
        end
    end

    // Count collisions, holding at the maximum.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            ncc <= '0;
        end else if (ev_collision && ncc != NCC_MAX) begin
            ncc <= ncc + 1'b1;
        end
    end

    // R6: the counter never wraps from its maximum.
    a_r6_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (ncc == NCC_MAX && !clr) |=> (ncc == NCC_MAX));
    // R4: a clear leaves every status field at zero, whatever events came.
    a_r4_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> ({crs, abt, owc, tok, tun} == 5'b0 && ncc == '0));
    // R5: a flag once set stays set until a clear.
    a_r5_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (crs && !clr) |=> crs);
endmodule

// File: rtl/txs_hb_timer.sv
// Heartbeat supervisor: after each send, waits HB_CYCLES edges for a
// collision-detect pulse and flags its absence. Idle at 100 Mbps.
module txs_hb_timer #(
    parameter int HB_CYCLES = 320
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic speed_100,
    input  logic start,
    input  logic hb_pulse,
    output logic hb_miss
);
    localparam int CNT_W = (HB_CYCLES > 1) ? $clog2(HB_CYCLES) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(HB_CYCLES - 1);

    logic             active;
    logic [CNT_W-1:0] cnt;

    // Run the window; a pulse closes it, expiry raises the flag.
    always_ff @(posedge clk) begin
        if (!rst_n || clr || speed_100) begin
            active  <= 1'b0;
            cnt     <= '0;
            hb_miss <= 1'b0;
        end else if (start) begin
            active <= 1'b1;
            cnt    <= '0;
        end else if (active) begin
            if (hb_pulse) begin
                active <= 1'b0;
            end else if (cnt == LAST) begin
                active  <= 1'b0;
                hb_miss <= 1'b1;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    // R10: the window counter stays inside the window length.
    a_r10_cnt_range: assert property (@(posedge clk) disable iff (!rst_n)
        active |-> (cnt <= LAST));
    // R8: at 100 Mbps the flag is held clear.
    a_r8_fast_clear: assert property (@(posedge clk) disable iff (!rst_n)
        speed_100 |=> !hb_miss);
    // R7: a heartbeat inside the window never produces the flag.
    a_r7_pulse_ok: assert property (@(posedge clk) disable iff (!rst_n)
        (active && hb_pulse && !hb_miss && !start) |=> !hb_miss);
endmodule

// File: rtl/txdesc_status_reg.sv
// Top: per-descriptor transmit status/control word. Qualifies host writes,
// drives the clear of status fields and assembles the read word.
module txdesc_status_reg
    import txs_pkg::*;
#(
    parameter int CLK_KHZ = 50000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_rst,
    input  logic              host_wr,
    input  logic [3:0]        host_be,
    input  logic [WORD_W-1:0] host_wdata,
    output logic [WORD_W-1:0] host_rdata,
    input  logic              ev_carrier_lost,
    input  logic              ev_abort,
    input  logic              ev_late_coll,
    input  logic              ev_collision,
    input  logic              ev_tx_ok,
    input  logic              ev_underrun,
    input  logic              ev_tx_done,
    input  logic              hb_pulse,
    input  logic              speed_100
);
    localparam int HB_CYCLES = hb_cycles(CLK_KHZ);

    logic             wr_ok, wr_partial, clr_status;
    logic [THR_W-1:0] thr;
    logic             own;
    logic [BC_W-1:0]  bc;
    logic             crs, abt, owc, tok, tun, hbm;
    logic [NCC_W-1:0] ncc;
    logic             unused_wdata;

    // Qualify writes: only full-word accesses count.
    always_comb begin
        wr_ok      = host_wr && (&host_be);
        wr_partial = host_wr && !(&host_be);
        clr_status = wr_ok || soft_rst;
    end

    assign unused_wdata = ^{host_wdata[31:22], host_wdata[15:14]};

    txs_host_regs u_host (
        .clk        (clk),
        .rst_n      (rst_n),
        .soft_rst   (soft_rst),
        .wr_ok      (wr_ok),
        .wr_partial (wr_partial),
        .wr_thr     (host_wdata[POS_THR +: THR_W]),
        .wr_own     (host_wdata[POS_OWN]),
        .wr_bc      (host_wdata[BC_W-1:0]),
        .thr        (thr),
        .own        (own),
        .bc         (bc)
    );

    txs_status_flags u_flags (
        .clk             (clk),
        .rst_n           (rst_n),
        .clr             (clr_status),
        .ev_carrier_lost (ev_carrier_lost),
        .ev_abort        (ev_abort),
        .ev_late_coll    (ev_late_coll),
        .ev_collision    (ev_collision),
        .ev_tx_ok        (ev_tx_ok),
        .ev_underrun     (ev_underrun),
        .crs             (crs),
        .abt             (abt),
        .owc             (owc),
        .tok             (tok),
        .tun             (tun),
        .ncc             (ncc)
    );

    txs_hb_timer #(.HB_CYCLES(HB_CYCLES)) u_hb (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (clr_status),
        .speed_100 (speed_100),
        .start     (ev_tx_done),
        .hb_pulse  (hb_pulse),
        .hb_miss   (hbm)
    );

    // Assemble the read word; reserved bits read zero.
    always_comb begin
        host_rdata = '0;
        host_rdata[POS_CRS]              = crs;
        host_rdata[POS_ABT]              = abt;
        host_rdata[POS_OWC]              = owc;
        host_rdata[POS_HBM]              = hbm;
        host_rdata[POS_NCC +: NCC_W]     = ncc;
        host_rdata[POS_THR +: THR_W]     = thr;
        host_rdata[POS_TOK]              = tok;
        host_rdata[POS_TUN]              = tun;
        host_rdata[POS_OWN]              = own;
        host_rdata[BC_W-1:0]             = bc;
    end

    // R3: reserved bits never read as one.
    a_r3_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        host_rdata[23:22] == 2'b00);
    // R4: an honoured write leaves the status fields clear on the next word.
    a_r4_write_clears: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ok |=> (host_rdata[31:24] == 8'h00 && host_rdata[15:14] == 2'b00));
    // R1: the first word after reset is the reset value.
    a_r1_reset_value: assert property (@(posedge clk)
        !rst_n |=> (host_rdata == 32'h0000_2000));
endmodule

// File: tb/txdesc_status_reg_bench.sv
module txdesc_status_reg_bench;
    localparam int HB = 320;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        soft_rst = 1'b0;
    logic        host_wr = 1'b0;
    logic [3:0]  host_be = 4'h0;
    logic [31:0] host_wdata = 32'h0;
    logic [31:0] host_rdata;
    logic        ev_carrier_lost = 1'b0, ev_abort = 1'b0, ev_late_coll = 1'b0;
    logic        ev_collision = 1'b0, ev_tx_ok = 1'b0, ev_underrun = 1'b0;
    logic        ev_tx_done = 1'b0, hb_pulse = 1'b0, speed_100 = 1'b1;

    int checks = 0;
    int errors = 0;
    logic [31:0] exp_w;
    bit done = 1'b0;

    always #10 clk = ~clk;

    txdesc_status_reg u_txdesc_status_reg (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
        .host_wr(host_wr), .host_be(host_be), .host_wdata(host_wdata),
        .host_rdata(host_rdata),
        .ev_carrier_lost(ev_carrier_lost), .ev_abort(ev_abort),
        .ev_late_coll(ev_late_coll), .ev_collision(ev_collision),
        .ev_tx_ok(ev_tx_ok), .ev_underrun(ev_underrun),
        .ev_tx_done(ev_tx_done), .hb_pulse(hb_pulse), .speed_100(speed_100)
    );

    // Model: next word from current word and one cycle of stimulus (no heartbeat).
    function automatic logic [31:0] model_next(input logic [31:0] cur, input logic srst,
            input logic wr, input logic [3:0] be, input logic [31:0] wd, input logic [5:0] ev);
        logic [31:0] n;
        logic [3:0]  c;
        n = cur;
        if (srst) begin
            n = 32'h0;
            n[13] = cur[13];
        end else if (wr && be == 4'hF) begin
            n = 32'h0;
            n[21:16] = wd[21:16];
            n[13]    = wd[13];
            n[12:0]  = wd[12:0];
        end else begin
            if (ev[0]) n[31] = 1'b1;
            if (ev[1]) n[30] = 1'b1;
            if (ev[2]) n[29] = 1'b1;
            if (ev[4]) n[15] = 1'b1;
            if (ev[5]) n[14] = 1'b1;
            c = cur[27:24];
            if (ev[3] && c != 4'hF) c = c + 4'd1;
            n[27:24] = c;
        end
        return n;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One clock: drive inputs, take the edge, release pulses, advance model.
    task automatic step(input logic srst, input logic wr, input logic [3:0] be,
                        input logic [31:0] wd, input logic [5:0] ev);
        soft_rst = srst; host_wr = wr; host_be = be; host_wdata = wd;
        {ev_underrun, ev_tx_ok, ev_collision, ev_late_coll, ev_abort, ev_carrier_lost} = ev;
        @(posedge clk);
        #2;
        soft_rst = 0; host_wr = 0; host_be = 0; host_wdata = 0;
        {ev_underrun, ev_tx_ok, ev_collision, ev_late_coll, ev_abort, ev_carrier_lost} = 6'h0;
        exp_w = model_next(exp_w, srst, wr, be, wd, ev);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #2;
            ev_tx_done = 0; hb_pulse = 0;
        end
    endtask

    initial begin
        #4_000_000;
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int unsigned seed;
        seed = 32'd1234;
        void'($urandom(seed));
        @(posedge clk); @(posedge clk); #2;
        rst_n = 1'b1;
        exp_w = 32'h0000_2000;
        check("R1 reset word", host_rdata, 32'h0000_2000);

        // R2: full write loads fields; R3: status/reserved data discarded.
        step(0, 1, 4'hF, 32'hFFFF_FFFF, 6'h0);
        check("R2/R3 full write all ones", host_rdata, 32'h003F_3FFF);
        // R2: partial write ignored.
        step(0, 1, 4'h7, 32'h0000_0000, 6'h0);
        check("R2 partial write ignored", host_rdata, 32'h003F_3FFF);
        // R5: each event flag.
        step(0, 0, 4'h0, 0, 6'b110111);
        check("R5 event flags", host_rdata, exp_w);
        check("R5 flag bits value", host_rdata & 32'hE000_C000, 32'hE000_C000);
        // R4: write with same-cycle events clears status.
        step(0, 1, 4'hF, 32'h0005_0123, 6'h3F);
        check("R4 clear wins over events", host_rdata, 32'h0005_0123);
        // R6: saturation at 15.
        for (int i = 0; i < 18; i++) step(0, 0, 4'h0, 0, 6'b001000);
        check("R6 collision count saturates", host_rdata[27:24], 32'hF);
        // R4: write clears count.
        step(0, 1, 4'hF, 32'h0000_2000, 6'h0);
        check("R4 write clears count", host_rdata, 32'h0000_2000);
        // R9: soft reset beats write, keeps own.
        step(0, 0, 4'h0, 0, 6'b000001);
        step(1, 1, 4'hF, 32'h0000_0000, 6'h0);
        check("R9 soft reset keeps own", host_rdata, 32'h0000_2000);

        // R7 / R10: missing heartbeat at 10 Mbps.
        speed_100 = 1'b0;
        ev_tx_done = 1'b1;
        idle(1);
        idle(HB - 1);
        check("R10 flag not yet set one edge early", {31'h0, host_rdata[28]}, 32'h0);
        idle(1);
        check("R7 heartbeat missing flag", {31'h0, host_rdata[28]}, 32'h1);
        // R4: write clears heartbeat flag.
        step(0, 1, 4'hF, 32'h0000_2000, 6'h0);
        check("R4 write clears heartbeat flag", host_rdata, 32'h0000_2000);
        // R7: pulse on the final window edge prevents the flag.
        ev_tx_done = 1'b1;
        idle(1);
        idle(HB - 1);
        hb_pulse = 1'b1;
        idle(1);
        idle(5);
        check("R7 late-window heartbeat accepted", {31'h0, host_rdata[28]}, 32'h0);
        // R8: at 100 Mbps no flag.
        speed_100 = 1'b1;
        ev_tx_done = 1'b1;
        idle(1);
        idle(HB + 5);
        check("R8 no heartbeat flag at 100 Mbps", {31'h0, host_rdata[28]}, 32'h0);

        // Constrained random mix (R2 R3 R4 R5 R6 R9).
        for (int i = 0; i < 400; i++) begin
            logic        r_srst, r_wr;
            logic [3:0]  r_be;
            logic [31:0] r_wd;
            logic [5:0]  r_ev;
            r_srst = ($urandom % 40) == 0;
            r_wr   = ($urandom % 6) == 0;
            r_be   = (($urandom % 3) == 0) ? 4'($urandom) : 4'hF;
            r_wd   = $urandom;
            r_ev   = 6'($urandom) & 6'($urandom);
            step(r_srst, r_wr, r_be, r_wd, r_ev);
            check("R2 R3 R4 R5 R6 R9 random step", host_rdata, exp_w);
        end

        // R1: reset again from a busy state.
        step(0, 1, 4'hF, 32'h0015_0ABC, 6'h0);
        rst_n = 1'b0;
        idle(1);
        rst_n = 1'b1;
        check("R1 reset from busy state", host_rdata, 32'h0000_2000);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule